// File: doc/BRIEF.md
# Sequential GF(2^8) Multiplicative Inverter

This block takes one field element and returns its multiplicative inverse in GF(2^M), M = 8 by default. It raises the operand to the power 2^M - 2. That power is the square of A^(2^(M-1) - 1), and the block builds that exponent with an addition chain. The chain follows the binary digits of M-1. The current partial result always has an exponent of the form 2^k - 1. For each further digit, the partial result is raised to the power 2^k and multiplied by its saved copy, which gives exponent 2^(2k) - 1. When the digit is a one, one more squaring and a multiply by A follow. The number of multiplies therefore grows with log M, not with M.

The datapath holds one standard-basis multiplier and one fixed XOR squaring network. A small controller sequences them. Raising to 2^k is done as k squaring cycles in a row. A host pulses `start` with the operand on `a_in`. It waits for the one-cycle `done` pulse and then reads `result`, which stays valid until the next operation is accepted. An operand of zero produces zero.

The reduction polynomial is a parameter. Its low M coefficients are given as a vector in which bit i is the coefficient of x^i, and x^M is implied. The default 8'h2D stands for x^8 + x^5 + x^3 + x^2 + 1.

Top module: `gf_inv_seq`

## Requirements
- R1: While reset is held and after it is released, before any operation, `done` is 0 and `result` is 0.
- R2: For every nonzero operand, the `result` presented with `done` multiplied by the operand equals 1. Multiplication is modulo x^8 + x^5 + x^3 + x^2 + 1, and bit i of a byte is the coefficient of x^i.
- R3: An operand of 0 produces a `result` of 0.
- R4: `start` is accepted only on a clock edge where the block is idle. `done` is then high for exactly one cycle, starting 11 clock edges after the accepting edge. `result` is valid in that cycle.
- R5: Changes on `start` or `a_in` while an operation is in flight, or during the `done` cycle, are ignored. The result belongs to the operand captured at the accepting edge.
- R6: After `done`, `result` holds its value until the next `start` is accepted.
- R7: Each inversion with M = 8 uses exactly 4 multiplier cycles (bit length of M-1 plus its count of ones, minus 2) and 7 single-squaring cycles. This is what gives the latency of R4.
- R8: A new `start` may be accepted on the first idle edge after `done`. Back-to-back operations each give their own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an inversion of `a_in` |
| a_in | input | 8 | Operand, standard basis |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 8 | Inverse of the captured operand |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the single `done` cycle, or while the chain is running, with a different operand on `a_in`. The block must drop that request and still report the first operand's inverse. To reach it, the bench holds `start` high and changes `a_in` on every cycle across an entire operation and the next one. Its cycle-level model tracks which edges may accept a request. The bench also sweeps all 256 operands, with zero-gap and one-cycle-gap spacing, so that the back-to-back acceptance right after `done` is exercised repeatedly.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DSQ  = 3'd1,
    ST_DMUL = 3'd2,
    ST_ASQ  = 3'd3,
    ST_AMUL = 3'd4,
    ST_FIN  = 3'd5,
    ST_DONE = 3'd6
  } inv_state_e;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_LOAD = 3'd1,
    OP_SQR  = 3'd2,
    OP_MULS = 3'd3,
    OP_MULA = 3'd4
  } inv_op_e;

  function automatic int ones_of(input int v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += (v >> i) & 1;
    return n;
  endfunction

endpackage

// File: rtl/gf_mult.sv
module gf_mult #(
  parameter int          M    = 8,
  parameter logic [M-1:0] POLY = 8'h2D
) (
  input  logic [M-1:0] x,
  input  logic [M-1:0] y,
  output logic [M-1:0] p
);
  // shift-and-add with reduction folded into each shift
  logic [M-1:0] part [M+1];
  logic [M-1:0] sh   [M+1];

  assign part[0] = '0;
  assign sh[0]   = x;

  for (genvar i = 0; i < M; i++) begin : g_row
    assign part[i+1] = part[i] ^ (y[i] ? sh[i] : '0);
    assign sh[i+1]   = {sh[i][M-2:0], 1'b0} ^ (sh[i][M-1] ? POLY : '0);
  end

  assign p = part[M];
endmodule

// File: rtl/gf_square.sv
module gf_square #(
  parameter int          M    = 8,
  parameter logic [M-1:0] POLY = 8'h2D
) (
  input  logic [M-1:0] x,
  output logic [M-1:0] q
);
  localparam int WW = 2*M - 1;

  logic [WW-1:0] spread;

  // coefficient i moves to position 2i
  for (genvar i = 0; i < M; i++) begin : g_spread
    assign spread[2*i] = x[i];
    if (i < M-1) begin : g_gap
      assign spread[2*i+1] = 1'b0;
    end
  end

  // fold powers >= M back with the field polynomial, top down
  always_comb begin
    logic [WW-1:0] w;
    w = spread;
    for (int j = WW-1; j >= M; j--) begin
      if (w[j]) begin
        w[j-M +: M] = w[j-M +: M] ^ POLY;
        w[j]        = 1'b0;
      end
    end
    q = w[M-1:0];
  end
endmodule

// File: rtl/gf_inv_ctrl.sv
module gf_inv_ctrl
  import gf_inv_pkg::*;
#(
  parameter int M = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output inv_op_e op,
  output logic    sav_ld,
  output logic    busy,
  output logic    done
);
  localparam int L    = $clog2(M);           // bit length of M-1
  localparam int KW   = L + 1;
  localparam int BW   = (L > 2) ? $clog2(L) : 1;
  localparam int MULS = L + ones_of(M-1) - 2;
  localparam logic [KW-1:0] CHAIN = KW'(M-1);
  localparam logic [BW-1:0] BIDX0 = BW'((L > 1) ? L-2 : 0);

  inv_state_e    st_q, st_n;
  logic [KW-1:0] k_q, k_n;
  logic [KW-1:0] cnt_q, cnt_n;
  logic [BW-1:0] bidx_q, bidx_n;

  always_comb begin
    st_n   = st_q;
    k_n    = k_q;
    cnt_n  = cnt_q;
    bidx_n = bidx_q;
    op     = OP_HOLD;
    sav_ld = 1'b0;
    done   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        op     = OP_LOAD;
        k_n    = KW'(1);
        cnt_n  = KW'(1);
        bidx_n = BIDX0;
        st_n   = (L > 1) ? ST_DSQ : ST_FIN;
      end
      ST_DSQ: begin
        op    = OP_SQR;
        cnt_n = cnt_q - KW'(1);
        if (cnt_q == KW'(1)) st_n = ST_DMUL;
      end
      ST_DMUL: begin
        op  = OP_MULS;
        k_n = k_q << 1;
        if (CHAIN[bidx_q]) st_n = ST_ASQ;
        else if (bidx_q == '0) st_n = ST_FIN;
        else begin
          sav_ld = 1'b1;
          bidx_n = bidx_q - BW'(1);
          cnt_n  = k_q << 1;
          st_n   = ST_DSQ;
        end
      end
      ST_ASQ: begin
        op   = OP_SQR;
        st_n = ST_AMUL;
      end
      ST_AMUL: begin
        op  = OP_MULA;
        k_n = k_q + KW'(1);
        if (bidx_q == '0) st_n = ST_FIN;
        else begin
          sav_ld = 1'b1;
          bidx_n = bidx_q - BW'(1);
          cnt_n  = k_q + KW'(1);
          st_n   = ST_DSQ;
        end
      end
      ST_FIN: begin
        op   = OP_SQR;
        st_n = ST_DONE;
      end
      ST_DONE: begin
        done = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      cnt_q  <= '0;
      bidx_q <= '0;
    end else begin
      st_q   <= st_n;
      k_q    <= k_n;
      cnt_q  <= cnt_n;
      bidx_q <= bidx_n;
    end
  end

  assign busy = (st_q != ST_IDLE);

  // multiplier-use counter, kept for the R7 check only
  logic [KW:0] mcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt_q <= '0;
    else if (op == OP_LOAD) mcnt_q <= '0;
    else if (op == OP_MULS || op == OP_MULA) mcnt_q <= mcnt_q + 1'b1;
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_mul_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mcnt_q == (KW+1)'(MULS)));

  p_accept_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |-> !busy);
endmodule

// File: rtl/gf_inv_seq.sv
module gf_inv_seq
  import gf_inv_pkg::*;
#(
  parameter int           M    = 8,
  parameter logic [M-1:0] POLY = 8'h2D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a_in,
  output logic         done,
  output logic [M-1:0] result
);
  inv_op_e      op;
  logic         sav_ld, busy;
  logic [M-1:0] a_q, acc_q, sav_q;
  logic [M-1:0] a_n, acc_n, sav_n;
  logic [M-1:0] sq_out, mul_out, mul_b;

  gf_inv_ctrl #(.M(M)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op(op), .sav_ld(sav_ld), .busy(busy), .done(done)
  );

  assign mul_b = (op == OP_MULA) ? a_q : sav_q;

  gf_mult #(.M(M), .POLY(POLY)) i_mul (.x(acc_q), .y(mul_b), .p(mul_out));
  gf_square #(.M(M), .POLY(POLY)) i_sqr (.x(acc_q), .q(sq_out));

  always_comb begin
    a_n   = a_q;
    acc_n = acc_q;
    sav_n = sav_q;
    unique case (op)
      OP_LOAD: begin
        a_n   = a_in;
        acc_n = a_in;
        sav_n = a_in;
      end
      OP_SQR:  acc_n = sq_out;
      OP_MULS, OP_MULA: begin
        acc_n = mul_out;
        if (sav_ld) sav_n = mul_out;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      acc_q <= '0;
      sav_q <= '0;
    end else begin
      a_q   <= a_n;
      acc_q <= acc_n;
      sav_q <= sav_n;
    end
  end

  assign result = acc_q;

  function automatic logic [M-1:0] chk_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [2*M-2:0] p;
    p = '0;
    for (int i = 0; i < M; i++) if (y[i]) p = p ^ ((2*M-1)'(x) << i);
    for (int j = 2*M-2; j >= M; j--) if (p[j]) p = p ^ ((2*M-1)'({1'b1, POLY}) << (j-M));
    return p[M-1:0];
  endfunction

  p_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && a_q != '0) |-> (chk_mul(result, a_q) == M'(1)));

  p_zero_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && a_q == '0) |-> (result == '0));

  p_opnd_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(a_q));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done || (!busy && !start)) |=> $stable(result));
endmodule

// File: tb/test_gf_inv_seq.sv
module test_gf_inv_seq;
  logic       clk, rst_n, start;
  logic [7:0] a_in;
  logic       done;
  logic [7:0] result;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  gf_inv_seq i_gf_inv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in),
    .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  // field arithmetic from R2, written plainly
  function automatic logic [7:0] fmul(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] p;
    p = 16'h0;
    for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (16'(x) << i);
    for (int j = 14; j >= 8; j--) if (p[j]) p = p ^ (16'h12D << (j - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] finv(input logic [7:0] x);
    for (int b = 1; b < 256; b++) if (fmul(x, 8'(b)) == 8'h01) return 8'(b);
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle-level reference model: 11 edges from acceptance to done (R4 R7)
  int         m_cnt;
  bit         m_done, m_hold;
  logic [7:0] m_op, m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_hold = 0; m_op = 0; m_res = 0;
    end else begin
      bit nd;
      nd = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          nd = 1; m_res = finv(m_op); m_hold = 1;
        end
      end else if (!m_done && start) begin
        m_cnt = 11; m_op = a_in; m_hold = 0;
      end
      m_done = nd;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(done == m_done, "R4 R7 R8 done timing", done, m_done);
      if (m_done)
        check(result == m_res, (m_op == 0) ? "R3 result" : "R2 result", result, m_res);
      else if (m_hold)
        check(result == m_res, "R6 hold", result, m_res);
    end
  end

  task automatic do_op(input logic [7:0] v, input int gap);
    int lat;
    @(negedge clk); start = 1'b1; a_in = v;
    @(negedge clk); start = 1'b0; a_in = ~v;
    lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    // accepted at the edge after the start negedge; done after 11 more edges -> 12th negedge
    check(lat == 12, "R4 latency", lat, 12);
    if (v == 8'h00) check(result == 8'h00, "R3 zero in", result, 0);
    else check(fmul(result, v) == 8'h01, "R2 product", fmul(result, v), 1);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; a_in = 8'h00;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(result == 8'h00, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(result == 8'h00, "R1 result after reset", result, 0);

    do_op(8'h00, 2);
    do_op(8'h01, 1);
    do_op(8'h02, 0);
    do_op(8'h80, 3);
    for (int v = 0; v < 256; v++) do_op(8'(v), v % 2);

    // R5: start held high with a changing operand across two operations
    @(negedge clk); start = 1'b1; a_in = 8'h53;
    begin
      int n;
      bit seen;
      seen = 0;
      for (n = 0; n < 30; n++) begin
        @(negedge clk);
        a_in = 8'(n * 37 + 11);
        if (done && !seen) begin
          seen = 1;
          check(result == finv(8'h53), "R5 busy start ignored", result, finv(8'h53));
        end
      end
      check(seen, "R5 done seen", seen, 1);
    end
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(done == 1'b0, "R6 idle no done", done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule